// File: doc/BRIEF.md
# One-Hot Selected 8-Bit ALU

This block is the arithmetic-logic unit of a small 8-bit processor datapath. It takes two operands, a carry input, a decimal-mode input and five function-select lines, one each for add, AND, OR, exclusive OR and shift right. The adder, the three bitwise units and the shifter all run in parallel on every cycle. The one active select picks which of them drives the result, the carry output and the overflow output.

The surrounding control logic builds the other operations from these five functions. Subtraction and compare load the inverted subtrahend with carry set. Shift left adds an operand to itself. Increment and decrement use a constant operand. The outputs are captured in a hold register on the rising clock edge. Results therefore appear one cycle after the inputs are presented.

The select lines are expected to be one-hot. When no select is active, the block reports that no result is valid. When more than one select is active, the block flags a select error and suppresses every output.

Top module: `onehot_alu8`

## Requirements
- R1: With only `sel_sum_i` high, `result_o` equals (`opa_i` + `opb_i` + `carry_i`) modulo 256, and `carry_o` equals bit 8 of that 9-bit sum.
- R2: With only `sel_and_i` high, `result_o` is the bitwise AND of the operands, and `carry_o` and `ovf_o` are 0.
- R3: With only `sel_or_i` high, `result_o` is the bitwise OR of the operands, and `carry_o` and `ovf_o` are 0.
- R4: With only `sel_xor_i` high, `result_o` is the bitwise exclusive OR of the operands, and `carry_o` and `ovf_o` are 0.
- R5: With only `sel_shr_i` high, `result_o` is {`carry_i`, `opa_i[7:1]`} and `carry_o` equals `opa_i[0]`. `opb_i` has no effect and `ovf_o` is 0.
- R6: `ovf_o` is 1 only when the add function is selected, both operand top bits are equal and the result top bit differs from them. For example, 0x7F+0x01 and 0x80+0xFF both overflow.
- R7: `dec_mode_i` has no effect on any output.
- R8: When no select is high, `result_o`, `carry_o`, `ovf_o`, `valid_o` and `sel_err_o` are all 0.
- R9: When two or more selects are high, `sel_err_o` is 1 and `result_o`, `carry_o`, `ovf_o` and `valid_o` are all 0.
- R10: When exactly one select is high, `valid_o` is 1 and `sel_err_o` is 0.
- R11: While `rst_n` is low, every output is 0.
- R12: All outputs are registered. Inputs sampled at one rising edge of `clk` appear at the outputs right after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the outputs are registered on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opa_i | input | 8 | First operand; also the source for shift right |
| opb_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry into the adder; fill bit for shift right |
| dec_mode_i | input | 1 | Decimal-mode request; accepted and ignored |
| sel_sum_i | input | 1 | Selects the add function |
| sel_and_i | input | 1 | Selects bitwise AND |
| sel_or_i | input | 1 | Selects bitwise OR |
| sel_xor_i | input | 1 | Selects bitwise exclusive OR |
| sel_shr_i | input | 1 | Selects shift right |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry output |
| ovf_o | output | 1 | Registered signed-overflow output |
| valid_o | output | 1 | Exactly one select was active |
| sel_err_o | output | 1 | More than one select was active |

## Verification
Every result, carry, overflow, valid and error output is due exactly one rising edge after the inputs that produce it. The driver changes the inputs on the falling edge and queues the expected outputs at the same moment. The monitor pops one entry shortly after each following rising edge, so each comparison lands in the single cycle where that result is held. The reset check samples the outputs while reset is still low, before any entry is queued.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    // Bit positions of the function-select vector assembled in the top.
    typedef enum int unsigned {
        FN_SUM = 0,
        FN_AND = 1,
        FN_OR  = 2,
        FN_XOR = 3,
        FN_SHR = 4
    } fn_e;

    localparam int unsigned NUM_FN = 5;

endpackage

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o
);

    // One slice per bit position; all three functions are always live.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
    end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    // Ripple-carry chain: sum bit = a ^ b ^ c, carry = majority(a, b, c).
    always_comb begin
        logic c;
        c = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            sum_o[i] = a_i[i] ^ b_i[i] ^ c;
            c        = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
        end
        cout_o = c;
    end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] res_o,
    output logic             out_bit_o
);

    localparam int unsigned MSB = WIDTH - 1;

    // Each result bit takes the operand bit one place above it.
    for (genvar i = 0; i < MSB; i++) begin : g_move
        assign res_o[i] = a_i[i+1];
    end

    assign res_o[MSB] = fill_i;
    assign out_bit_o  = a_i[0];

endmodule

// File: rtl/onehot_alu8.sv
module onehot_alu8
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             carry_i,
    input  logic             dec_mode_i,
    input  logic             sel_sum_i,
    input  logic             sel_and_i,
    input  logic             sel_or_i,
    input  logic             sel_xor_i,
    input  logic             sel_shr_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             valid_o,
    output logic             sel_err_o
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cy;
        logic             ov;
        logic             vld;
        logic             err;
    } hold_t;

    logic [NUM_FN-1:0] sel;
    logic [WIDTH-1:0]  and_w, or_w, xor_w, sum_w, shr_w;
    logic              add_cout_w, shr_cout_w, add_ovf_w;
    hold_t             hold_d, hold_q;

    // Select lines gathered into one vector, indexed by fn_e.
    assign sel[FN_SUM] = sel_sum_i;
    assign sel[FN_AND] = sel_and_i;
    assign sel[FN_OR]  = sel_or_i;
    assign sel[FN_XOR] = sel_xor_i;
    assign sel[FN_SHR] = sel_shr_i;

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .and_o (and_w),
        .or_o  (or_w),
        .xor_o (xor_w)
    );

    alu8_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (carry_i),
        .sum_o  (sum_w),
        .cout_o (add_cout_w)
    );

    alu8_shifter #(.WIDTH(WIDTH)) u_shifter (
        .a_i       (opa_i),
        .fill_i    (carry_i),
        .res_o     (shr_w),
        .out_bit_o (shr_cout_w)
    );

    // Signed overflow: operands share a sign and the sum's sign differs.
    assign add_ovf_w = (opa_i[MSB] ~^ opb_i[MSB]) & (opa_i[MSB] ^ sum_w[MSB]);

    always_comb begin
        hold_d = '0;
        if ($countones(sel) > 1) begin
            hold_d.err = 1'b1;
        end else if (sel != '0) begin
            hold_d.vld = 1'b1;
            unique case (1'b1)
                sel[FN_SUM]: begin
                    hold_d.res = sum_w;
                    hold_d.cy  = add_cout_w;
                    hold_d.ov  = add_ovf_w;
                end
                sel[FN_AND]: hold_d.res = and_w;
                sel[FN_OR]:  hold_d.res = or_w;
                sel[FN_XOR]: hold_d.res = xor_w;
                sel[FN_SHR]: begin
                    hold_d.res = shr_w;
                    hold_d.cy  = shr_cout_w;
                end
                default: hold_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign result_o  = hold_q.res;
    assign carry_o   = hold_q.cy;
    assign ovf_o     = hold_q.ov;
    assign valid_o   = hold_q.vld;
    assign sel_err_o = hold_q.err;

endmodule

// File: rtl/alu8_checks.sv
module alu8_checks #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             carry_i,
    input logic             dec_mode_i,
    input logic             sel_sum_i,
    input logic             sel_and_i,
    input logic             sel_or_i,
    input logic             sel_xor_i,
    input logic             sel_shr_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             valid_o,
    input logic             sel_err_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [4:0]     sels;
    logic [WIDTH:0] sum_ref;
    logic           sum_only, shr_only;

    assign sels     = {sel_shr_i, sel_xor_i, sel_or_i, sel_and_i, sel_sum_i};
    assign sum_ref  = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, carry_i};
    assign sum_only = (sels == 5'b00001);
    assign shr_only = (sels == 5'b10000);

    // R1 and R7: the add result holds whatever the decimal-mode input is.
    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sum_only |=> (result_o == $past(sum_ref[WIDTH-1:0]) && carry_o == $past(sum_ref[WIDTH])));

    p_sum_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_only && dec_mode_i) |=> (result_o == $past(sum_ref[WIDTH-1:0])));

    p_shr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shr_only |=> (result_o == {$past(carry_i), $past(opa_i[MSB:1])}
                      && carry_o == $past(opa_i[0]) && !ovf_o));

    p_ovf_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_sum_i |=> !ovf_o);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sels == 5'b0) |=> (result_o == '0 && !carry_o && !ovf_o && !valid_o && !sel_err_o));

    p_multi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sels) > 1) |=> (sel_err_o && !valid_o && result_o == '0 && !carry_o && !ovf_o));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && sel_err_o));

    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sels) |=> valid_o);

endmodule

bind onehot_alu8 alu8_checks #(.WIDTH(WIDTH)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .carry_i    (carry_i),
    .dec_mode_i (dec_mode_i),
    .sel_sum_i  (sel_sum_i),
    .sel_and_i  (sel_and_i),
    .sel_or_i   (sel_or_i),
    .sel_xor_i  (sel_xor_i),
    .sel_shr_i  (sel_shr_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o),
    .valid_o    (valid_o),
    .sel_err_o  (sel_err_o)
);

// File: tb/sim_onehot_alu8.sv
module sim_onehot_alu8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = '0, opb = '0;
    logic       cin = 1'b0, dec = 1'b0;
    logic [4:0] sel = '0;   // {shr, xor, or, and, sum}
    logic [7:0] result;
    logic       carry, ovf, valid, sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       cy;
        logic       ov;
        logic       vld;
        logic       err;
        string      req;
    } exp_t;

    exp_t scb[$];

    always #5 clk = ~clk;

    onehot_alu8 u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .opa_i      (opa),
        .opb_i      (opb),
        .carry_i    (cin),
        .dec_mode_i (dec),
        .sel_sum_i  (sel[0]),
        .sel_and_i  (sel[1]),
        .sel_or_i   (sel[2]),
        .sel_xor_i  (sel[3]),
        .sel_shr_i  (sel[4]),
        .result_o   (result),
        .carry_o    (carry),
        .ovf_o      (ovf),
        .valid_o    (valid),
        .sel_err_o  (sel_err)
    );

    function automatic exp_t model(logic [7:0] a, logic [7:0] b, logic c,
                                   logic [4:0] s, string req);
        exp_t e;
        int   n = 0;
        e.res = '0; e.cy = 1'b0; e.ov = 1'b0; e.vld = 1'b0; e.err = 1'b0;
        e.req = req;
        for (int i = 0; i < 5; i++) n += int'(s[i]);
        if (n > 1) begin
            e.err = 1'b1;
        end else if (n == 1) begin
            e.vld = 1'b1;
            case (s)
                5'b00001: begin
                    logic [8:0] w;
                    int t;
                    w = {1'b0, a} + {1'b0, b} + {8'b0, c};
                    e.res = w[7:0];
                    e.cy  = w[8];
                    t = int'($signed(a)) + int'($signed(b)) + int'(c);
                    e.ov = (t > 127) || (t < -128);
                end
                5'b00010: e.res = a & b;
                5'b00100: e.res = a | b;
                5'b01000: e.res = a ^ b;
                default: begin
                    e.res = {c, a[7:1]};
                    e.cy  = a[0];
                end
            endcase
        end
        return e;
    endfunction

    task automatic drive(logic [7:0] a, logic [7:0] b, logic c, logic d,
                         logic [4:0] s, string req);
        @(negedge clk);
        opa = a; opb = b; cin = c; dec = d; sel = s;
        scb.push_back(model(a, b, c, s, req));
    endtask

    // Monitor: each queued item is due just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (scb.size() != 0) begin
                exp_t e;
                e = scb.pop_front();
                checks++;
                if (result !== e.res || carry !== e.cy || ovf !== e.ov ||
                    valid !== e.vld || sel_err !== e.err) begin
                    fails++;
                    $display("FAIL %s: got res=%02h cy=%b ov=%b vld=%b err=%b, exp res=%02h cy=%b ov=%b vld=%b err=%b",
                             e.req, result, carry, ovf, valid, sel_err,
                             e.res, e.cy, e.ov, e.vld, e.err);
                end
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R11: outputs are cleared while reset is held, even with live inputs.
        @(negedge clk);
        opa = 8'hFF; opb = 8'hFF; cin = 1'b1; sel = 5'b00001;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result !== 8'h00 || carry || ovf || valid || sel_err) begin
            fails++;
            $display("FAIL R11: got res=%02h cy=%b ov=%b vld=%b err=%b, exp all zero",
                     result, carry, ovf, valid, sel_err);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R6: overflow and carry boundaries
        drive(8'h7F, 8'h01, 1'b0, 1'b0, 5'b00001, "R6");
        drive(8'h80, 8'hFF, 1'b0, 1'b0, 5'b00001, "R6");
        drive(8'hFF, 8'h00, 1'b1, 1'b0, 5'b00001, "R1");
        drive(8'h7F, 8'h00, 1'b1, 1'b0, 5'b00001, "R6");
        drive(8'h50, 8'hAF, 1'b1, 1'b0, 5'b00001, "R1");
        // R7: decimal mode changes nothing
        drive(8'h19, 8'h28, 1'b0, 1'b1, 5'b00001, "R7");
        drive(8'h09, 8'h01, 1'b1, 1'b1, 5'b00001, "R7");
        // R2 / R3 / R4
        drive(8'hF0, 8'h3C, 1'b1, 1'b0, 5'b00010, "R2");
        drive(8'hA5, 8'h5A, 1'b1, 1'b0, 5'b00100, "R3");
        drive(8'hFF, 8'h0F, 1'b1, 1'b0, 5'b01000, "R4");
        // R5: shift right, fill from carry, B ignored
        drive(8'h81, 8'h00, 1'b1, 1'b0, 5'b10000, "R5");
        drive(8'h81, 8'hFF, 1'b1, 1'b0, 5'b10000, "R5");
        drive(8'h02, 8'h55, 1'b0, 1'b0, 5'b10000, "R5");
        // R6: overflow suppressed outside add
        drive(8'h7F, 8'h7F, 1'b1, 1'b0, 5'b00100, "R6");
        // R8: idle
        drive(8'h7F, 8'h01, 1'b1, 1'b0, 5'b00000, "R8");
        // R9: multiple selects
        drive(8'h7F, 8'h01, 1'b1, 1'b0, 5'b10001, "R9");
        drive(8'hFF, 8'hFF, 1'b1, 1'b0, 5'b11111, "R9");
        // R10 / R12: back-to-back one-hot selects, one cycle each
        drive(8'h12, 8'h34, 1'b0, 1'b0, 5'b00010, "R12");
        drive(8'h12, 8'h34, 1'b0, 1'b0, 5'b01000, "R12");
        drive(8'h12, 8'h34, 1'b0, 1'b0, 5'b00001, "R10");

        for (int k = 0; k < 400; k++) begin
            logic [4:0] s;
            s = 5'b00001 << (k % 5);
            drive(8'($urandom), 8'($urandom), 1'(k / 5), 1'($urandom),
                  s, (k % 5 == 0) ? "R1" : (k % 5 == 1) ? "R2" :
                     (k % 5 == 2) ? "R3" : (k % 5 == 3) ? "R4" : "R5");
        end
        for (int k = 0; k < 40; k++) begin
            drive(8'($urandom), 8'($urandom), 1'($urandom), 1'b0,
                  5'($urandom), "R9");
        end

        @(negedge clk);
        sel = '0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule